// File: doc/BRIEF.md
# Threaded Code Prefetch Walker

This block walks threaded code held in a tagged program memory and turns it into a flat stream of executable tokens. The sequencer that consumes the stream never interprets a thread. Each 24-bit memory word carries a 2-bit tag in bits 23:22. A primitive word holds a 22-bit token that is passed on unchanged. Bit 21 of that token tells the consumer whether it selects one microcode word or starts a short microcode sequence. A call word holds a 22-bit target address. A return word ends the current definition.

On a call, the walker saves the address of the following word on its own return stack, which is 16 entries deep. It then fetches from the target. On a return, it pops that address and resumes there. A return with nothing on the stack ends the walk. Only primitives reach the FIFO write port; call and return words are never written.

The walk runs while the consumer drains the FIFO. When the FIFO reports full, the walker holds off without dropping or duplicating the pending token. A one-cycle start pulse begins a new walk from a given entry address and abandons any walk in progress.

Top module: `thread_walker`

## Requirements
- R1: While reset is held and after its release, busy, done, overflowErr, fifoWrEn and memRdEn are all low.
- R2: A startPulse loads startAddr, empties the return stack and clears done and overflowErr. In the next cycle busy is high and a read of startAddr is issued.
- R3: A word with tag 00 in bits 23:22 is a primitive. Its low 22 bits, including the kind flag in bit 21, are written to the FIFO unchanged and in program order.
- R4: A word with tag 01 is a call. The address after the call word is pushed and fetching continues at the target in bits 21:0. The call word itself is never written to the FIFO.
- R5: A word with tag 10, or the reserved tag 11, is a return. With a non-empty stack, fetching resumes at the most recently pushed address, and the return word is never written to the FIFO.
- R6: A return with an empty stack ends the walk. busy falls and done rises, and no further reads or FIFO writes occur until the next start.
- R7: Up to 16 nested calls proceed normally. A call made with 16 entries already on the stack sets overflowErr and halts the walk with done low. overflowErr stays set until the next start.
- R8: fifoWrEn is never high while fifoFull is high. A primitive held back by full is written exactly once after full clears.
- R9: Memory reads have one cycle of latency and at most one read is issued per cycle. A word returned by a read issued before a redirect (call, return, replay or start) is discarded.
- R10: A startPulse during a walk abandons it. The outputs then follow only the new walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a new walk |
| startAddr | input | 22 | Entry address of the walk |
| memRdEn | output | 1 | Program memory read request |
| memRdAddr | output | 22 | Program memory read address |
| memRdData | input | 24 | Read data, valid the cycle after the request |
| fifoWrEn | output | 1 | Write one token into the sequencer FIFO |
| fifoWrData | output | 22 | Primitive token |
| fifoFull | input | 1 | FIFO cannot accept a write this cycle |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | The last walk ended normally |
| overflowErr | output | 1 | The last walk halted on return stack overflow |

## Verification
The bench goes after these corner cases:
- Nesting that reaches exactly 16 levels, and a self-recursive definition that pushes a seventeenth entry. A walker with an off-by-one stack limit would either halt early or corrupt the oldest return address.
- Long and random stretches of FIFO full. These expose a walker that drops the pending token or emits it twice, which shows up as a missing or repeated token in the stream.
- Calls and returns back to back, and a restart in mid-walk. A walker that lets the speculative word behind a redirect through would emit a stray token, or the word after a call.

// File: rtl/thread_walk_pkg.sv
package thread_walk_pkg;

  typedef enum logic [1:0] {
    TAG_PRIM = 2'b00,
    TAG_CALL = 2'b01,
    TAG_RET  = 2'b10,
    TAG_RSV  = 2'b11
  } wordTag_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadStart;
    logic issue;
    logic push;
    logic pop;
    logic jump;
    logic replay;
  } walkStrb_t;

endpackage

// File: rtl/thread_walk_ctrl.sv
module thread_walk_ctrl
  import thread_walk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      startPulse,
  input  logic      fifoFull,
  input  wordTag_t  wordTag,
  input  logic      stackEmpty,
  input  logic      stackFull,
  output walkStrb_t strb,
  output logic      memRdEn,
  output logic      fifoWrEn,
  output logic      busy,
  output logic      done,
  output logic      overflowErr
);

  logic active;
  logic rdValid;
  logic doneQ;
  logic errQ;
  logic wordValid;
  logic finish;
  logic overflow;
  logic emit;
  logic redirect;

  assign wordValid = active && rdValid;

  always_comb begin
    strb       = '0;
    finish     = 1'b0;
    overflow   = 1'b0;
    emit       = 1'b0;
    strb.issue = active;
    if (startPulse) begin
      strb.loadStart = 1'b1;
    end else if (wordValid) begin
      unique case (wordTag)
        TAG_PRIM: begin
          if (fifoFull) strb.replay = 1'b1;
          else          emit        = 1'b1;
        end
        TAG_CALL: begin
          if (stackFull) begin
            overflow = 1'b1;
          end else begin
            strb.push = 1'b1;
            strb.jump = 1'b1;
          end
        end
        default: begin
          if (stackEmpty) finish   = 1'b1;
          else            strb.pop = 1'b1;
        end
      endcase
    end
  end

  assign redirect = strb.replay | strb.jump | strb.pop | finish | overflow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      rdValid <= 1'b0;
      doneQ   <= 1'b0;
      errQ    <= 1'b0;
    end else if (startPulse) begin
      active  <= 1'b1;
      rdValid <= 1'b0;
      doneQ   <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      rdValid <= active && !redirect;
      if (finish) begin
        active <= 1'b0;
        doneQ  <= 1'b1;
      end
      if (overflow) begin
        active <= 1'b0;
        errQ   <= 1'b1;
      end
    end
  end

  assign memRdEn     = active;
  assign fifoWrEn    = emit;
  assign busy        = active;
  assign done        = doneQ;
  assign overflowErr = errQ;

endmodule

// File: rtl/thread_walk_dp.sv
module thread_walk_dp
  import thread_walk_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int RS_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walkStrb_t         strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W+1:0] memRdData,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] fifoWrData,
  output wordTag_t          wordTag,
  output logic              stackEmpty,
  output logic              stackFull
);

  localparam int WORD_W = ADDR_W + 2;
  localparam int SP_W   = $clog2(RS_DEPTH + 1);
  localparam int IDX_W  = (RS_DEPTH > 1) ? $clog2(RS_DEPTH) : 1;

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] rdAddr;
  logic [SP_W-1:0]   sp;
  logic [ADDR_W-1:0] slotQ [RS_DEPTH];
  logic [IDX_W-1:0]  pushIdx;
  logic [IDX_W-1:0]  popIdx;
  logic [ADDR_W-1:0] retAddr;
  logic [ADDR_W-1:0] target;

  assign target     = memRdData[ADDR_W-1:0];
  assign wordTag    = wordTag_t'(memRdData[WORD_W-1 -: 2]);
  assign fifoWrData = memRdData[ADDR_W-1:0];
  assign retAddr    = rdAddr + ADDR_W'(1);
  assign pushIdx    = IDX_W'(sp);
  assign popIdx     = IDX_W'(sp - SP_W'(1));
  assign stackEmpty = (sp == '0);
  assign stackFull  = (sp == SP_W'(RS_DEPTH));
  assign memRdAddr  = pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc     <= '0;
      rdAddr <= '0;
      sp     <= '0;
    end else if (strb.loadStart) begin
      pc <= startAddr;
      sp <= '0;
    end else begin
      if (strb.issue) rdAddr <= pc;
      if (strb.push)      sp <= sp + SP_W'(1);
      else if (strb.pop)  sp <= sp - SP_W'(1);
      if (strb.jump)        pc <= target;
      else if (strb.pop)    pc <= slotQ[popIdx];
      else if (strb.replay) pc <= rdAddr;
      else if (strb.issue)  pc <= pc + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push && !strb.loadStart) slotQ[pushIdx] <= retAddr;
  end

endmodule

// File: rtl/thread_walker.sv
module thread_walker
  import thread_walk_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int RS_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startPulse,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [ADDR_W+1:0] memRdData,
  output logic              fifoWrEn,
  output logic [ADDR_W-1:0] fifoWrData,
  input  logic              fifoFull,
  output logic              busy,
  output logic              done,
  output logic              overflowErr
);

  walkStrb_t strb;
  wordTag_t  wordTag;
  logic      stackEmpty;
  logic      stackFull;

  thread_walk_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startPulse (startPulse),
    .fifoFull   (fifoFull),
    .wordTag    (wordTag),
    .stackEmpty (stackEmpty),
    .stackFull  (stackFull),
    .strb       (strb),
    .memRdEn    (memRdEn),
    .fifoWrEn   (fifoWrEn),
    .busy       (busy),
    .done       (done),
    .overflowErr(overflowErr)
  );

  thread_walk_dp #(
    .ADDR_W  (ADDR_W),
    .RS_DEPTH(RS_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .startAddr (startAddr),
    .memRdData (memRdData),
    .memRdAddr (memRdAddr),
    .fifoWrData(fifoWrData),
    .wordTag   (wordTag),
    .stackEmpty(stackEmpty),
    .stackFull (stackFull)
  );

endmodule

// File: rtl/thread_walker_chk.sv
module thread_walker_chk (
  input logic clk,
  input logic rst_n,
  input logic startPulse,
  input logic fifoFull,
  input logic fifoWrEn,
  input logic memRdEn,
  input logic busy,
  input logic done,
  input logic overflowErr
);

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifoWrEn |-> !fifoFull);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !fifoWrEn && !memRdEn));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflowErr && !startPulse) |=> overflowErr);

  // R7
  err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflowErr |-> (!done && !busy));

  // R2
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> (busy && !done && !overflowErr));

  // R9
  read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memRdEn |-> busy);

  // R3
  write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifoWrEn |-> busy);

endmodule

bind thread_walker thread_walker_chk u_walk_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .startPulse (startPulse),
  .fifoFull   (fifoFull),
  .fifoWrEn   (fifoWrEn),
  .memRdEn    (memRdEn),
  .busy       (busy),
  .done       (done),
  .overflowErr(overflowErr)
);

// File: tb/thread_walker_bench.sv
`timescale 1ns/1ps
module thread_walker_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        startPulse;
  logic [21:0] startAddr;
  logic        memRdEn;
  logic [21:0] memRdAddr;
  logic [23:0] memRdData;
  logic        fifoWrEn;
  logic [21:0] fifoWrData;
  logic        fifoFull;
  logic        busy;
  logic        done;
  logic        overflowErr;

  always #2.5 clk = ~clk;

  thread_walker u_thread_walker (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .startAddr(startAddr),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .fifoFull(fifoFull),
    .busy(busy), .done(done), .overflowErr(overflowErr)
  );

  logic [23:0] progMem [0:1023];
  always @(posedge clk) if (memRdEn) memRdData <= progMem[memRdAddr[9:0]];

  int          total = 0;
  int          bad = 0;
  int          cyc = 0;
  int          fullMode = 0;
  bit          ignoreWr = 1'b0;
  logic [21:0] expQ[$];

  function automatic logic [23:0] prim(input logic [21:0] t); return {2'b00, t}; endfunction
  function automatic logic [23:0] call(input logic [21:0] a); return {2'b01, a}; endfunction
  function automatic logic [23:0] ret10(); return {2'b10, 22'h0}; endfunction
  function automatic logic [23:0] ret11(); return {2'b11, 22'h0}; endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference walk: builds the expected token stream
  task automatic refWalk(input int a, output bit ovf);
    int stk[$];
    int pc = a;
    logic [23:0] w;
    expQ.delete();
    ovf = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      w = progMem[pc[9:0]];
      case (w[23:22])
        2'b00: begin expQ.push_back(w[21:0]); pc++; end
        2'b01: begin
          if (stk.size() == 16) begin ovf = 1'b1; return; end
          stk.push_back(pc + 1);
          pc = int'(w[21:0]);
        end
        default: begin
          if (stk.size() == 0) return;
          pc = stk.pop_back();
        end
      endcase
    end
  endtask

  // one clock: drive at the falling edge, then compare against the model
  task automatic step(input bit st, input logic [21:0] a);
    @(negedge clk);
    cyc++;
    startPulse = st;
    startAddr  = a;
    case (fullMode)
      1:       fifoFull = 1'($urandom_range(0, 1));
      2:       fifoFull = ((cyc % 16) < 11);
      default: fifoFull = 1'b0;
    endcase
    #1;
    if (fifoWrEn) begin
      check(!fifoFull, "R8", "write while full", fifoFull, 0);
      if (!ignoreWr) begin
        if (expQ.size() == 0) check(0, "R3", "unexpected token", fifoWrData, 0);
        else begin
          logic [21:0] e;
          e = expQ.pop_front();
          check(fifoWrData == e, "R3", "token", fifoWrData, e);
        end
      end
    end
  endtask

  task automatic runWalk(input logic [21:0] a, input string name);
    bit ovf;
    refWalk(int'(a), ovf);
    ignoreWr = 1'b0;
    step(1'b1, a);
    step(1'b0, '0);
    check(busy, "R2", {name, " busy after start"}, busy, 1);
    check(memRdEn && memRdAddr == a, "R2", {name, " first read"}, memRdAddr, a);
    check(!overflowErr && !done, "R2", {name, " flags cleared"}, {done, overflowErr}, 0);
    for (int i = 0; i < 5000 && busy; i++) step(1'b0, '0);
    check(!busy, "R6", {name, " walk ended"}, busy, 0);
    check(done == !ovf, "R6", {name, " done"}, done, !ovf);
    check(overflowErr == ovf, "R7", {name, " overflow"}, overflowErr, ovf);
    check(expQ.size() == 0, "R9", {name, " tokens left"}, expQ.size(), 0);
    for (int i = 0; i < 3; i++) begin
      step(1'b0, '0);
      check(!fifoWrEn && !memRdEn, "R6", {name, " idle after end"},
            {fifoWrEn, memRdEn}, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R6 watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) progMem[i] = ret10();
    // flat definition, one token with the sequence flag (bit 21)
    progMem[16] = prim(22'h000011);
    progMem[17] = prim(22'h200022);
    progMem[18] = prim(22'h000033);
    progMem[19] = ret10();
    // nested calls, back-to-back call/return, reserved-tag return
    progMem[64] = prim(22'h000101);
    progMem[65] = call(22'd128);
    progMem[66] = prim(22'h000102);
    progMem[67] = call(22'd128);
    progMem[68] = call(22'd160);
    progMem[69] = ret10();
    progMem[128] = prim(22'h200201);
    progMem[129] = call(22'd160);
    progMem[130] = prim(22'h000202);
    progMem[131] = ret11();
    progMem[160] = prim(22'h000301);
    progMem[161] = ret10();
    // self-recursion: overflow on the 17th push
    progMem[256] = prim(22'h000155);
    progMem[257] = call(22'd256);
    // exactly 16 nested levels
    for (int k = 0; k < 16; k++) begin
      progMem[768 + 4*k]     = prim(22'(32'h400 + k));
      progMem[768 + 4*k + 1] = call(22'(768 + 4*(k+1)));
      progMem[768 + 4*k + 2] = prim(22'(32'h500 + k));
      progMem[768 + 4*k + 3] = ret10();
    end
    progMem[768 + 64] = prim(22'h0003ff);
    progMem[768 + 65] = ret10();

    rst_n = 1'b0; startPulse = 1'b0; startAddr = '0; fifoFull = 1'b0;
    repeat (4) @(negedge clk);
    check(!busy && !done && !overflowErr && !fifoWrEn && !memRdEn, "R1",
          "reset outputs", {busy, done, overflowErr, fifoWrEn, memRdEn}, 0);
    rst_n = 1'b1;
    step(1'b0, '0);
    check(!busy && !done && !memRdEn, "R1", "after reset", {busy, done, memRdEn}, 0);

    runWalk(22'd16, "R3 flat");
    runWalk(22'd64, "R4 R5 nested");
    runWalk(22'd768, "R7 depth16");
    runWalk(22'd256, "R7 overflow");
    for (int i = 0; i < 4; i++) step(1'b0, '0);
    check(overflowErr && !busy, "R7", "sticky error", overflowErr, 1);
    runWalk(22'd16, "R7 cleared");

    fullMode = 1;
    runWalk(22'd64, "R8 random full");
    runWalk(22'd768, "R9 random full deep");
    fullMode = 2;
    runWalk(22'd64, "R8 long full");

    // R10 restart in the middle of a walk
    fullMode = 0;
    ignoreWr = 1'b1;
    step(1'b1, 22'd768);
    for (int i = 0; i < 7; i++) step(1'b0, '0);
    runWalk(22'd64, "R10 restart");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule